// File: doc/BRIEF.md
# HD Output Gain and Sync Inserter

This block is a per-pixel stage placed in front of three 10-bit video DACs. It takes a three-channel pixel stream (RGB or Y-Pb-Pr) together with valid, blanking and sync strobes from an external timing generator. It returns three DAC codes two clock cycles later. The image is not scaled: each pixel in gives one pixel out, and the strobes are delayed by the same two cycles as the data.

Two gain modes are available. In full-swing mode the pixel codes pass through unchanged. In reduced mode the video is multiplied by 707/1024, which is close to 0.69, with rounding. The result is lifted above a blank pedestal, and this leaves room below the video for a sync pulse inserted digitally. The pulse is either a bi-level pulse down to code 0, or a tri-level pulse. The tri-level pulse dips to 0 for its first part and then rises by the same excursion above the pedestal.

Sync always goes on the green/Y channel. Each of the other two channels has its own enable. A format select sets whether channels 0 and 2 are treated as colour-difference channels (mid-scale blank, scaled about mid-scale) or as RGB primaries. A Y-Pb-Pr input is never treated as RGB.

Top module: `hd_gain_sync`

## Requirements
- R1: `out_valid`, `out_sync`, `out_blank` and `out_code` reflect the inputs presented exactly two rising clock edges earlier.
- R2: With `gain_reduce`=0 and `in_blank`=0, every channel code equals its input code, and `in_sync` has no effect on the codes.
- R3: With `gain_reduce`=0 and `in_blank`=1, RGB and Y channels output 0 and colour-difference channels output 512.
- R4: With `gain_reduce`=1 on an active pixel, an RGB or Y channel outputs 300 + floor((x*707+512)/1024). Examples: x=0 gives 300, x=512 gives 654, x=1023 gives 1006.
- R5: With `gain_reduce`=1 on an active pixel, a colour-difference channel outputs 512 + floor(((x-512)*707+512)/1024). Examples: x=0 gives 159, x=1023 gives 865.
- R6: With `gain_reduce`=1 and `in_blank`=1 and no sync, RGB and Y channels output the pedestal 300, and colour-difference channels output 512.
- R7: With `gain_reduce`=1, `sync_tri`=0 and `in_sync`=1, every sync-carrying channel outputs 0, whatever the state of blank or the video.
- R8: With `gain_reduce`=1 and `sync_tri`=1, a sync-carrying channel outputs 0 for the first 4 cycles of each sync pulse and 600 (pedestal plus 300) for the rest of the pulse. A new pulse restarts at 0.
- R9: Channel 1 (G/Y) always carries sync. Channel 0 carries sync only when `sync_en_side[0]`=1, and channel 2 only when `sync_en_side[1]`=1. A channel that does not carry sync outputs its blank level during sync.
- R10: Channels 0 and 2 are colour-difference channels when `in_is_ycc`=1 or `out_rgb_sel`=0. They are RGB primaries only when `in_is_ycc`=0 and `out_rgb_sel`=1, so an RGB request on a Y-Pb-Pr input is forced to Y-Pb-Pr.
- R11: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Pixel valid strobe |
| in_sync | input | 1 | Sync interval strobe |
| in_blank | input | 1 | Blanking interval strobe |
| in_pix | input | 30 | Input codes, channel c at bits [10c+9:10c] (0=R/Pr, 1=G/Y, 2=B/Pb) |
| in_is_ycc | input | 1 | Input stream is Y-Pb-Pr |
| out_rgb_sel | input | 1 | Request RGB channel roles |
| gain_reduce | input | 1 | 1 = 707/1024 gain with sync insertion, 0 = full swing |
| sync_tri | input | 1 | 1 = tri-level sync, 0 = bi-level sync |
| sync_en_side | input | 2 | Sync enable for channel 0 (bit 0) and channel 2 (bit 1) |
| out_valid | output | 1 | Delayed valid strobe |
| out_sync | output | 1 | Delayed sync strobe |
| out_blank | output | 1 | Delayed blank strobe |
| out_code | output | 30 | DAC codes, same channel layout as `in_pix` |

## Verification
The hardest case to reach is the tri-level step inside a single sync pulse. The output level depends on how many cycles the sync strobe has already been high, so no steady input vector can show it. The stimulus holds sync high for eight cycles in a row and checks the green channel at every edge, so the exact cycle of the 0-to-600 step is pinned. It then drops sync for a short gap and raises it again, to show that the phase count restarts.

// File: rtl/hd_gain_sync_pkg.sv
package hd_gain_sync_pkg;

    localparam int CH_N     = 3;
    localparam int CH_PRI_A = 0;   // R or Pr
    localparam int CH_MAIN  = 1;   // G or Y, always carries sync
    localparam int CH_PRI_B = 2;   // B or Pb

    typedef enum logic {
        ROLE_LUMA   = 1'b0,
        ROLE_CHROMA = 1'b1
    } ch_role_e;

endpackage

// File: rtl/hd_gain_scale.sv
module hd_gain_scale #(
    parameter int DW         = 10,
    parameter int GAIN_NUM   = 707,
    parameter int GAIN_SHIFT = 10,
    parameter int BLANK_LVL  = 300
) (
    input  logic          reduce,
    input  hd_gain_sync_pkg::ch_role_e role,
    input  logic [DW-1:0] pix,
    output logic [DW-1:0] code
);
    import hd_gain_sync_pkg::*;

    localparam int MID     = 1 << (DW - 1);
    localparam int CODE_MX = (1 << DW) - 1;
    localparam int HALF_LSB = 1 << (GAIN_SHIFT - 1);

    int centered;
    int product;
    int rounded;
    int lifted;

    always_comb begin
        centered = (role == ROLE_CHROMA) ? (int'(pix) - MID) : int'(pix);
        product  = centered * GAIN_NUM;
        rounded  = (product + HALF_LSB) >>> GAIN_SHIFT;
        lifted   = rounded + ((role == ROLE_CHROMA) ? MID : BLANK_LVL);
        if (lifted < 0) begin
            lifted = 0;
        end else if (lifted > CODE_MX) begin
            lifted = CODE_MX;
        end
        code = reduce ? DW'(lifted) : pix;
    end

endmodule

// File: rtl/hd_gain_tri_timer.sv
module hd_gain_tri_timer #(
    parameter int HALF_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    output logic phase_hi
);
    localparam int CW = $clog2(HALF_LEN + 1);
    localparam logic [CW-1:0] CNT_TOP = CW'(HALF_LEN);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!sync_in) begin
            cnt_d = '0;
        end else if (cnt_q != CNT_TOP) begin
            cnt_d = cnt_q + 1'b1;
        end
        phase_hi = sync_in && (cnt_q == CNT_TOP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/hd_gain_level_mux.sv
module hd_gain_level_mux #(
    parameter int DW        = 10,
    parameter int BLANK_LVL = 300
) (
    input  logic          reduce,
    input  hd_gain_sync_pkg::ch_role_e role,
    input  logic          carries_sync,
    input  logic          tri_mode,
    input  logic          tri_hi,
    input  logic          sync,
    input  logic          blank,
    input  logic [DW-1:0] scaled,
    output logic [DW-1:0] code
);
    import hd_gain_sync_pkg::*;

    localparam logic [DW-1:0] MID_CODE  = DW'(1 << (DW - 1));
    localparam logic [DW-1:0] PED_CODE  = DW'(BLANK_LVL);
    localparam logic [DW-1:0] TRI_CODE  = DW'(2 * BLANK_LVL);

    logic [DW-1:0] blank_code;

    always_comb begin
        if (role == ROLE_CHROMA) begin
            blank_code = MID_CODE;
        end else begin
            blank_code = reduce ? PED_CODE : '0;
        end

        if (!reduce) begin
            code = blank ? blank_code : scaled;
        end else if (sync && carries_sync) begin
            code = (tri_mode && tri_hi) ? TRI_CODE : '0;
        end else if (sync || blank) begin
            code = blank_code;
        end else begin
            code = scaled;
        end
    end

endmodule

// File: rtl/hd_gain_sync.sv
module hd_gain_sync #(
    parameter int DW            = 10,
    parameter int GAIN_NUM      = 707,
    parameter int GAIN_SHIFT    = 10,
    parameter int BLANK_LVL     = 300,
    parameter int SYNC_HALF_LEN = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic                in_sync,
    input  logic                in_blank,
    input  logic [3*DW-1:0]     in_pix,
    input  logic                in_is_ycc,
    input  logic                out_rgb_sel,
    input  logic                gain_reduce,
    input  logic                sync_tri,
    input  logic [1:0]          sync_en_side,
    output logic                out_valid,
    output logic                out_sync,
    output logic                out_blank,
    output logic [3*DW-1:0]     out_code
);
    import hd_gain_sync_pkg::*;

    typedef struct packed {
        logic                       valid;
        logic                       sync;
        logic                       blank;
        logic                       reduce;
        logic                       tri_mode;
        logic                       tri_hi;
        logic [CH_N-1:0]            chroma;
        logic [CH_N-1:0]            carries;
        logic [CH_N-1:0][DW-1:0]    scaled;
    } stage1_t;

    typedef struct packed {
        logic                       valid;
        logic                       sync;
        logic                       blank;
        logic [CH_N-1:0][DW-1:0]    code;
    } stage2_t;

    stage1_t s1_d, s1_q;
    stage2_t s2_d, s2_q;

    logic                    ycc_roles;
    logic                    tri_hi_now;
    logic [CH_N-1:0]         chroma_now;
    logic [CH_N-1:0]         carries_now;
    logic [CH_N-1:0][DW-1:0] scaled_now;
    logic [CH_N-1:0][DW-1:0] code_now;

    assign ycc_roles = in_is_ycc || !out_rgb_sel;

    hd_gain_tri_timer #(
        .HALF_LEN (SYNC_HALF_LEN)
    ) u_tri (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_in  (in_sync),
        .phase_hi (tri_hi_now)
    );

    for (genvar c = 0; c < CH_N; c++) begin : g_ch
        if (c == CH_MAIN) begin : g_main
            assign chroma_now[c]  = 1'b0;
            assign carries_now[c] = 1'b1;
        end else begin : g_side
            assign chroma_now[c]  = ycc_roles;
            assign carries_now[c] = (c == CH_PRI_A) ? sync_en_side[0] : sync_en_side[1];
        end

        hd_gain_scale #(
            .DW         (DW),
            .GAIN_NUM   (GAIN_NUM),
            .GAIN_SHIFT (GAIN_SHIFT),
            .BLANK_LVL  (BLANK_LVL)
        ) u_scale (
            .reduce (gain_reduce),
            .role   (chroma_now[c] ? ROLE_CHROMA : ROLE_LUMA),
            .pix    (in_pix[c*DW +: DW]),
            .code   (scaled_now[c])
        );

        hd_gain_level_mux #(
            .DW        (DW),
            .BLANK_LVL (BLANK_LVL)
        ) u_mux (
            .reduce       (s1_q.reduce),
            .role         (s1_q.chroma[c] ? ROLE_CHROMA : ROLE_LUMA),
            .carries_sync (s1_q.carries[c]),
            .tri_mode     (s1_q.tri_mode),
            .tri_hi       (s1_q.tri_hi),
            .sync         (s1_q.sync),
            .blank        (s1_q.blank),
            .scaled       (s1_q.scaled[c]),
            .code         (code_now[c])
        );
    end

    always_comb begin
        s1_d          = s1_q;
        s1_d.valid    = in_valid;
        s1_d.sync     = in_sync;
        s1_d.blank    = in_blank;
        s1_d.reduce   = gain_reduce;
        s1_d.tri_mode = sync_tri;
        s1_d.tri_hi   = tri_hi_now;
        s1_d.chroma   = chroma_now;
        s1_d.carries  = carries_now;
        s1_d.scaled   = scaled_now;

        s2_d          = s2_q;
        s2_d.valid    = s1_q.valid;
        s2_d.sync     = s1_q.sync;
        s2_d.blank    = s1_q.blank;
        s2_d.code     = code_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign out_valid = s2_q.valid;
    assign out_sync  = s2_q.sync;
    assign out_blank = s2_q.blank;
    assign out_code  = s2_q.code;

endmodule

// File: rtl/hd_gain_sync_chk.sv
module hd_gain_sync_chk #(
    parameter int DW        = 10,
    parameter int BLANK_LVL = 300
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            in_sync,
    input logic            in_blank,
    input logic [3*DW-1:0] in_pix,
    input logic            gain_reduce,
    input logic            sync_tri,
    input logic            out_valid,
    input logic            out_sync,
    input logic            out_blank,
    input logic [3*DW-1:0] out_code
);
    logic [1:0] warm_q;
    logic [DW-1:0] main_code;

    assign main_code = out_code[DW +: DW];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm_q <= '0;
        end else if (warm_q != 2'd2) begin
            warm_q <= warm_q + 2'd1;
        end
    end

    // R1: strobes and codes trail the inputs by two edges
    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |-> (out_valid == $past(in_valid, 2)
                              && out_sync == $past(in_sync, 2)
                              && out_blank == $past(in_blank, 2)));

    // R2: full swing passes active pixels unchanged
    p_full_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2 && $past(!gain_reduce && !in_blank, 2))
        |-> (out_code == $past(in_pix, 2)));

    // R3: full swing blanking puts the main channel at zero
    p_full_blank_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2 && $past(!gain_reduce && in_blank, 2))
        |-> (main_code == '0));

    // R7: bi-level sync pulls the main channel to zero
    p_bi_sync_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2 && out_sync && $past(gain_reduce && !sync_tri, 2))
        |-> (main_code == '0));

    // R8: tri-level sync uses only the two sync levels
    p_tri_levels_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2 && out_sync && $past(gain_reduce && sync_tri, 2))
        |-> (main_code == '0 || main_code == DW'(2 * BLANK_LVL)));

    // R11: reset clears every output
    p_reset_r11: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_sync && !out_blank && out_code == '0));

endmodule

bind hd_gain_sync hd_gain_sync_chk #(
    .DW        (DW),
    .BLANK_LVL (BLANK_LVL)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_sync     (in_sync),
    .in_blank    (in_blank),
    .in_pix      (in_pix),
    .gain_reduce (gain_reduce),
    .sync_tri    (sync_tri),
    .out_valid   (out_valid),
    .out_sync    (out_sync),
    .out_blank   (out_blank),
    .out_code    (out_code)
);

// File: tb/hd_gain_sync_tb.sv
module hd_gain_sync_tb;

    localparam int DW = 10;
    localparam int NV = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic            in_sync = 1'b0;
    logic            in_blank = 1'b0;
    logic [3*DW-1:0] in_pix = '0;
    logic            in_is_ycc = 1'b0;
    logic            out_rgb_sel = 1'b1;
    logic            gain_reduce = 1'b0;
    logic            sync_tri = 1'b0;
    logic [1:0]      sync_en_side = 2'b00;
    logic            out_valid;
    logic            out_sync;
    logic            out_blank;
    logic [3*DW-1:0] out_code;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    hd_gain_sync u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_sync      (in_sync),
        .in_blank     (in_blank),
        .in_pix       (in_pix),
        .in_is_ycc    (in_is_ycc),
        .out_rgb_sel  (out_rgb_sel),
        .gain_reduce  (gain_reduce),
        .sync_tri     (sync_tri),
        .sync_en_side (sync_en_side),
        .out_valid    (out_valid),
        .out_sync     (out_sync),
        .out_blank    (out_blank),
        .out_code     (out_code)
    );

    // fields: reduce, ycc, rgb_sel, blank, sync, en[1:0], pix0..2, exp0..2
    localparam logic [66:0] VEC [NV] = '{
        {1'b0,1'b0,1'b1,1'b0,1'b0,2'b00,10'd100,10'd200,10'd300,10'd100,10'd200,10'd300}, // R2
        {1'b0,1'b1,1'b0,1'b0,1'b1,2'b11,10'd700,10'd512,10'd300,10'd700,10'd512,10'd300}, // R2 sync ignored
        {1'b0,1'b1,1'b0,1'b1,1'b0,2'b00,10'd700,10'd512,10'd300,10'd512,10'd0,10'd512},   // R3
        {1'b0,1'b0,1'b1,1'b1,1'b0,2'b00,10'd700,10'd512,10'd300,10'd0,10'd0,10'd0},       // R3 R10
        {1'b1,1'b0,1'b1,1'b0,1'b0,2'b00,10'd0,10'd512,10'd1023,10'd300,10'd654,10'd1006}, // R4
        {1'b1,1'b0,1'b1,1'b0,1'b0,2'b00,10'd100,10'd200,10'd1023,10'd369,10'd438,10'd1006}, // R4
        {1'b1,1'b1,1'b0,1'b0,1'b0,2'b00,10'd700,10'd512,10'd300,10'd642,10'd654,10'd366}, // R5
        {1'b1,1'b1,1'b0,1'b0,1'b0,2'b00,10'd0,10'd1023,10'd1023,10'd159,10'd1006,10'd865}, // R5
        {1'b1,1'b1,1'b1,1'b0,1'b0,2'b00,10'd0,10'd0,10'd1023,10'd159,10'd300,10'd865},    // R10 forced
        {1'b1,1'b0,1'b0,1'b0,1'b0,2'b00,10'd0,10'd0,10'd0,10'd159,10'd300,10'd159},       // R10
        {1'b1,1'b1,1'b0,1'b1,1'b0,2'b00,10'd900,10'd900,10'd900,10'd512,10'd300,10'd512}, // R6
        {1'b1,1'b0,1'b1,1'b1,1'b0,2'b00,10'd900,10'd900,10'd900,10'd300,10'd300,10'd300}, // R6
        {1'b1,1'b0,1'b1,1'b1,1'b1,2'b00,10'd900,10'd900,10'd900,10'd300,10'd0,10'd300},   // R7 R9
        {1'b1,1'b0,1'b1,1'b1,1'b1,2'b11,10'd900,10'd900,10'd900,10'd0,10'd0,10'd0},       // R9
        {1'b1,1'b1,1'b0,1'b1,1'b1,2'b01,10'd900,10'd900,10'd900,10'd0,10'd0,10'd512},     // R9
        {1'b1,1'b1,1'b0,1'b0,1'b1,2'b10,10'd900,10'd900,10'd900,10'd512,10'd0,10'd0}      // R7 over video
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int code_of(input int c);
        return int'(out_code[c*DW +: DW]);
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 8);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        // R11: outputs idle during reset
        repeat (3) @(posedge clk);
        #1;
        check("R11", "valid", int'(out_valid), 0);
        check("R11", "code", int'(out_code == '0), 1);
        @(negedge clk);
        rst_n = 1'b1;

        // table walk
        for (int i = 0; i < NV; i++) begin
            logic [66:0] v;
            v = VEC[i];
            @(negedge clk);
            gain_reduce  = v[66];
            in_is_ycc    = v[65];
            out_rgb_sel  = v[64];
            in_blank     = v[63];
            in_sync      = v[62];
            sync_en_side = v[61:60];
            in_pix       = {v[39:30], v[49:40], v[59:50]};
            in_valid     = i[0];
            sync_tri     = 1'b0;
            repeat (3) @(posedge clk);
            #1;
            check("R1", "valid", int'(out_valid), int'(i[0]));
            check("R1", "sync", int'(out_sync), int'(v[62]));
            check("R1", "blank", int'(out_blank), int'(v[63]));
            check("R4 R5 R9 vec", $sformatf("v%0d ch0", i), code_of(0), int'(v[29:20]));
            check("R4 R5 R9 vec", $sformatf("v%0d ch1", i), code_of(1), int'(v[19:10]));
            check("R4 R5 R9 vec", $sformatf("v%0d ch2", i), code_of(2), int'(v[9:0]));
        end

        // R1: exact edge of a code change
        @(negedge clk);
        gain_reduce = 1'b0; in_sync = 1'b0; in_blank = 1'b0;
        in_pix = {10'd0, 10'd111, 10'd0};
        repeat (3) @(posedge clk);
        @(negedge clk);
        in_pix = {10'd0, 10'd222, 10'd0};
        @(posedge clk); #1;
        check("R1", "one edge after change", code_of(1), 111);
        @(posedge clk); #1;
        check("R1", "two edges after change", code_of(1), 222);

        // R8: tri-level step inside one pulse
        @(negedge clk);
        gain_reduce = 1'b1; sync_tri = 1'b1; in_blank = 1'b1;
        in_is_ycc = 1'b0; out_rgb_sel = 1'b1; sync_en_side = 2'b00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        in_sync = 1'b1;
        @(posedge clk);
        for (int j = 0; j < 8; j++) begin
            @(posedge clk); #1;
            check("R8", $sformatf("pulse cycle %0d", j), code_of(1), (j >= 4) ? 600 : 0);
            check("R9", $sformatf("side ch0 cycle %0d", j), code_of(0), 300);
        end
        @(negedge clk);
        in_sync = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        in_sync = 1'b1;
        @(posedge clk);
        @(posedge clk); #1;
        check("R8", "restart low", code_of(1), 0);

        // R11: reset in the middle of traffic
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R11", "mid-run sync", int'(out_sync), 0);
        check("R11", "mid-run code", int'(out_code == '0), 1);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        finish_run();
    end

endmodule